// File: doc/BRIEF.md
# Entropy-Mixed Shift-Register Random Word Source with Read-Once Slots

This block produces 32-bit random words from a linear feedback shift register. The register steps on a strobe formed from several internal activity signals. An entropy bit taken from system state is folded into its feedback on every step. After a programmable number of steps, the current register value is committed into a small ring of slots. A commit always replaces the oldest slot and marks that slot fresh.

A consumer requests a word by pulsing a read request. The block returns the oldest fresh word on the next cycle and retires it at once, so no word is ever handed out twice. When no fresh word is waiting, the read comes back with the valid flag low and zero data, and an empty flag warns the consumer beforehand.

Commits are paced by a two-state sequencer. In COUNT it tallies steps. When a step completes the programmed count, the transition COUNT→PUSH is taken; otherwise COUNT→COUNT. PUSH writes the register value to the ring for one cycle. It leaves by PUSH→COUNT, or stays by PUSH→PUSH when the step in that cycle completes another count.

Top module: `entropy_ring_rng`

## Requirements
- R1: The register steps only in a cycle where the strobe is high. The strobe is the odd parity (XOR) of the step_src bits. A step shifts the state left by one bit. The new bit 0 is the XOR of state bits 31, 21, 1 and 0 and entropy_bit. With the strobe low, the state holds.
- R2: If a step would produce the all-zero state, the register loads the constant 0x6D2B79F5 instead. Reset also loads this constant.
- R3: Let K be commit_len, with 0 treated as 1. On the K-th step since the previous commit, the register value right after that step is committed to the ring at the following clock edge.
- R4: The ring has 4 slots, written in rotation. A commit overwrites the oldest slot and marks it fresh. With all 4 slots fresh, a commit discards the oldest fresh word.
- R5: A read request with at least one fresh slot returns the oldest fresh word. rd_data carries the word and rd_valid is high for exactly the next cycle. The slot's fresh mark is cleared, so the word is never returned again.
- R6: A read request with no fresh slot gives rd_valid low and rd_data zero in the next cycle. rd_data is zero in every cycle where rd_valid is low.
- R7: empty is high exactly when no slot is fresh. It reflects commits and reads from the cycle after their clock edge.
- R8: When a read and a commit fall on the same edge, the read sees the slot contents from before that edge. If the ring was full, the read returns the oldest word and the new word stays fresh.
- R9: Reset clears all fresh marks and the step count. Reset drives rd_valid and rd_data low and empty high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_src | input | 3 | Internal activity signals whose parity forms the step strobe |
| entropy_bit | input | 1 | System-state bit folded into the feedback on each step |
| commit_len | input | 6 | Steps per committed word (0 acts as 1) |
| rd_req | input | 1 | Read request, one word per cycle |
| rd_valid | output | 1 | High for one cycle when a fresh word is returned |
| rd_data | output | 32 | Returned word, zero when rd_valid is low |
| empty | output | 1 | No fresh word is waiting |

## Verification
The bench steers the entropy bit so that the feedback is cancelled for 32 steps. The register is then driven toward zero. A design that failed to catch this would lock up and commit zeros instead of the reseed constant. The bench also fills the ring beyond four words without reading. A design with a wrong overwrite or search order would return a discarded or out-of-order word. A read landing on the same edge as a commit into a full ring checks that the newest word survives and the old word is not served twice. Empty reads check that no stale data leaks out. A commit length of one with back-to-back steps checks that the sequencer stays in PUSH and drops no word.

// File: rtl/rng_pkg.sv
package rng_pkg;
    typedef enum logic [0:0] {
        CM_COUNT = 1'b0,
        CM_PUSH  = 1'b1
    } commit_state_e;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
    parameter int          W        = 32,
    parameter logic [W-1:0] TAP_MASK = 32'h8020_0003,
    parameter logic [W-1:0] SEED     = 32'h6D2B_79F5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         ent,
    output logic [W-1:0] state_o
);
    logic [W-1:0] state_q;
    logic [W-1:0] shifted;
    logic         fb;

    always_comb begin
        fb      = (^(state_q & TAP_MASK)) ^ ent;
        shifted = {state_q[W-2:0], fb};
        // a zero state would lock the register: reseed instead
        if (shifted == '0) begin
            shifted = SEED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= shifted;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/rng_commit_fsm.sv
module rng_commit_fsm
    import rng_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             push_o
);
    commit_state_e    state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   limit_eff;
    logic [CNT_W:0]   cnt_inc;
    logic             hit;

    always_comb begin
        limit_eff = (limit == '0) ? (CNT_W+1)'(1) : {1'b0, limit};
        cnt_inc   = {1'b0, cnt_q} + (CNT_W+1)'(1);
        hit       = step && (cnt_inc >= limit_eff);
        cnt_d     = cnt_q;
        if (step) begin
            cnt_d = hit ? '0 : cnt_inc[CNT_W-1:0];
        end
        state_d = state_q;
        unique case (state_q)
            CM_COUNT: state_d = hit ? CM_PUSH : CM_COUNT;
            CM_PUSH:  state_d = hit ? CM_PUSH : CM_COUNT;
            default:  state_d = CM_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CM_COUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            CM_COUNT: push_o = 1'b0;
            CM_PUSH:  push_o = 1'b1;
            default:  push_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rng_slot_ring.sv
module rng_slot_ring #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_req,
    output logic             rd_valid,
    output logic [W-1:0]     rd_data,
    output logic             empty,
    output logic [DEPTH-1:0] fresh_o
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [DEPTH-1:0] fresh_q, fresh_d;
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] sel_idx;
    logic             sel_hit;
    logic             take;

    // oldest fresh slot: search forward from the write pointer
    always_comb begin
        logic [PTR_W-1:0] cand;
        sel_hit = 1'b0;
        sel_idx = '0;
        cand    = '0;
        for (int k = 0; k < DEPTH; k++) begin
            cand = wr_ptr_q + PTR_W'(k);
            if (!sel_hit && fresh_q[cand]) begin
                sel_hit = 1'b1;
                sel_idx = cand;
            end
        end
        take    = rd_req && sel_hit;
        fresh_d = fresh_q;
        if (take) begin
            fresh_d[sel_idx] = 1'b0;
        end
        if (wr_en) begin
            fresh_d[wr_ptr_q] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fresh_q  <= '0;
            wr_ptr_q <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            fresh_q  <= fresh_d;
            rd_valid <= take;
            rd_data  <= take ? mem[sel_idx] : '0;
            if (wr_en) begin
                wr_ptr_q <= wr_ptr_q + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr_q] <= wr_data;
        end
    end

    assign empty   = ~|fresh_q;
    assign fresh_o = fresh_q;
endmodule

// File: rtl/entropy_ring_rng.sv
module entropy_ring_rng #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    parameter int CNT_W = 6,
    parameter int SRC_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] step_src,
    input  logic             entropy_bit,
    input  logic [CNT_W-1:0] commit_len,
    input  logic             rd_req,
    output logic             rd_valid,
    output logic [W-1:0]     rd_data,
    output logic             empty
);
    logic             step_en;
    logic             push;
    logic [W-1:0]     lfsr_q;
    logic [DEPTH-1:0] fresh_q;

    assign step_en = ^step_src;

    rng_lfsr #(.W(W)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step_en),
        .ent     (entropy_bit),
        .state_o (lfsr_q)
    );

    rng_commit_fsm #(.CNT_W(CNT_W)) u_commit (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step_en),
        .limit  (commit_len),
        .push_o (push)
    );

    rng_slot_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push),
        .wr_data  (lfsr_q),
        .rd_req   (rd_req),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .empty    (empty),
        .fresh_o  (fresh_q)
    );
endmodule

// File: rtl/rng_checker.sv
module rng_checker #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_en,
    input logic             push,
    input logic             rd_req,
    input logic             rd_valid,
    input logic [W-1:0]     rd_data,
    input logic             empty,
    input logic [W-1:0]     lfsr_q,
    input logic [DEPTH-1:0] fresh
);
    a_r1_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(lfsr_q));

    a_r2_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    a_r3_push_follows_step: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(step_en));

    a_r5_read_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !empty && !push) |=> ($countones(fresh) == $countones($past(fresh)) - 1));

    a_r5_valid_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty) |=> (!rd_valid && rd_data == '0));

    a_r6_data_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0);

    a_r4_commit_marks_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !empty);
endmodule

bind entropy_ring_rng rng_checker #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .push     (push),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .empty    (empty),
    .lfsr_q   (lfsr_q),
    .fresh    (fresh_q)
);

// File: tb/entropy_ring_rng_bench.sv
module entropy_ring_rng_bench;
    localparam int          W     = 32;
    localparam int          DEPTH = 4;
    localparam logic [31:0] TAPS  = 32'h8020_0003;
    localparam logic [31:0] SEED  = 32'h6D2B_79F5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  step_src = '0;
    logic        entropy_bit = 1'b0;
    logic [5:0]  commit_len = 6'd1;
    logic        rd_req = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        empty;

    always #2 clk = ~clk;

    entropy_ring_rng u_entropy_ring_rng (
        .clk(clk), .rst_n(rst_n), .step_src(step_src), .entropy_bit(entropy_bit),
        .commit_len(commit_len), .rd_req(rd_req), .rd_valid(rd_valid),
        .rd_data(rd_data), .empty(empty)
    );

    int    tests = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    chk_on = 1'b0;
    string tag = "R9";

    // behavioural reference
    logic [31:0] m_lfsr;
    int          m_cnt;
    bit          m_push;
    bit          m_valid;
    logic [31:0] m_data;
    logic [31:0] q[$];

    function automatic logic [31:0] step_next(logic [31:0] s, logic e);
        logic [31:0] n;
        n = {s[30:0], (^(s & TAPS)) ^ e};
        return (n == 32'h0) ? SEED : n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lfsr = SEED; m_cnt = 0; m_push = 0; m_valid = 0; m_data = 0;
            q.delete();
        end else begin
            logic [31:0] word;
            int          lim;
            bit          np;
            word = m_lfsr;
            if (rd_req && q.size() > 0) begin
                m_valid = 1; m_data = q.pop_front();
            end else begin
                m_valid = 0; m_data = 0;
            end
            if (m_push) begin
                if (q.size() == DEPTH) void'(q.pop_front());
                q.push_back(word);
            end
            lim = (commit_len == 0) ? 1 : int'(commit_len);
            np = 0;
            if (^step_src) begin
                m_lfsr = step_next(m_lfsr, entropy_bit);
                if (m_cnt + 1 >= lim) begin m_cnt = 0; np = 1; end
                else m_cnt = m_cnt + 1;
            end
            m_push = np;
        end
    end

    task automatic check(string t, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", t, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            check(tag, "empty", {31'b0, empty}, {31'b0, q.size() == 0});
            check(tag, "rd_valid", {31'b0, rd_valid}, {31'b0, m_valid});
            check(tag, "rd_data", rd_data, m_data);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic do_reset();
        chk_on = 0;
        @(negedge clk);
        rst_n = 0; step_src = 0; rd_req = 0; entropy_bit = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_on = 1;
    endtask

    task automatic cyc_drive(logic [2:0] src, logic e, logic rd);
        @(negedge clk);
        step_src = src; entropy_bit = e; rd_req = rd;
    endtask

    initial begin
        // R9: reset state
        tag = "R9";
        do_reset();
        cyc_drive(3'b000, 0, 0);
        cyc_drive(3'b000, 0, 1);
        cyc_drive(3'b000, 0, 0);

        // R1 / R3: single-step commits with varied strobe patterns
        tag = "R1"; commit_len = 6'd1;
        cyc_drive(3'b001, 1, 0);
        cyc_drive(3'b011, 0, 0);   // even parity: no step
        cyc_drive(3'b111, 0, 0);
        cyc_drive(3'b000, 0, 1);
        cyc_drive(3'b000, 0, 1);
        cyc_drive(3'b000, 0, 0);

        // R3: multi-step commit with commit_len 5, and 0 acting as 1
        tag = "R3"; commit_len = 6'd5;
        for (int i = 0; i < 12; i++) cyc_drive(3'b100, i[0], 0);
        cyc_drive(3'b000, 0, 1);
        cyc_drive(3'b000, 0, 1);
        commit_len = 6'd0;
        cyc_drive(3'b010, 1, 0);
        cyc_drive(3'b000, 0, 1);
        cyc_drive(3'b000, 0, 1);

        // R4: overfill the ring, back-to-back commits (sequencer stays in PUSH)
        tag = "R4"; commit_len = 6'd1;
        for (int i = 0; i < 7; i++) cyc_drive(3'b001, i[1], 0);
        cyc_drive(3'b000, 0, 0);
        cyc_drive(3'b000, 0, 0);

        // R5: drain in order, then R6: reads on an empty ring
        tag = "R5";
        for (int i = 0; i < 4; i++) cyc_drive(3'b000, 0, 1);
        tag = "R6";
        for (int i = 0; i < 3; i++) cyc_drive(3'b000, 0, 1);
        tag = "R7";
        cyc_drive(3'b000, 0, 0);

        // R8: read on the same edge as a commit into a full ring
        tag = "R8";
        for (int i = 0; i < 4; i++) cyc_drive(3'b001, 1, 0);
        cyc_drive(3'b001, 0, 0);   // commit of word 4 pending
        cyc_drive(3'b000, 0, 1);   // read collides with that commit
        for (int i = 0; i < 5; i++) cyc_drive(3'b000, 0, 1);

        // R2: cancel the feedback so the register heads to zero
        tag = "R2";
        do_reset();
        commit_len = 6'd32;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            step_src = 3'b001; rd_req = 0;
            entropy_bit = ^(m_lfsr & TAPS);
        end
        cyc_drive(3'b000, 0, 0);
        cyc_drive(3'b000, 0, 0);
        cyc_drive(3'b000, 0, 1);
        @(negedge clk);
        rd_req = 0;
        check("R2", "reseed word", rd_data, SEED);
        check("R2", "reseed valid", {31'b0, rd_valid}, 32'd1);

        // mixed random traffic across all rules
        tag = "R5";
        for (int i = 0; i < 3000; i++) begin
            if (i % 500 == 0) commit_len = 6'($urandom_range(0, 9));
            cyc_drive(3'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0));
        end
        cyc_drive(3'b000, 0, 0);
        cyc_drive(3'b000, 0, 0);
        chk_on = 0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule